// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged and hypervisor control state of one processor strand. Scalar control registers, eight scratch slots, eight queue pointers and a small stack of trap-save registers per trap level sit behind one register index space. A combinational read port returns the addressed register in the same cycle. A synchronous write port updates it at the next rising clock edge.

Each register has its own write rule. The processor-state and trap-base registers are masked on write. The window pointer saturates at the highest window. The trap level is kept to its implemented width. The five trap-save registers always resolve to the entry selected by the current trap level. Each write to the trap level re-evaluates an interrupt request for a return to trap level zero. The block also packs fields from several registers into a read-only control word that it drives to the MMU.

Illegal accesses raise an error flag in the same cycle and have no side effect. These are unimplemented indices, writes to the packed word, and trap-save accesses at a trap level with no entry.

Top module: `priv_ctrl_regfile`

## Requirements
- R1: After reset, hypervisor state (index 7) reads 0x800, strand status (index 14) reads 0x50000, FPRS (index 1) reads 0x3, every other implemented register reads 0, and both the interrupt request and the packed word are 0.
- R2: Index map: 0 ASI, 1 FPRS, 2 processor state, 3 trap level, 4 interrupt level, 5 window pointer, 6 global level, 7 hypervisor state, 8 trap base, 9 hypervisor trap base, 10 primary context, 11 secondary context, 12 partition, 13 LSU control, 14 strand status, 15 packed word, 16..20 trap PC / next PC / state / type / hypervisor state, 24..31 scratch, 32..39 queue head/tail pointers. Plain registers store all 64 bits. A read returns data in the same cycle. A read of a register in the cycle it is written returns the old value, and the new value is visible from the next cycle.
- R3: Writes to the processor-state register keep only bits 1..4, 6..9 and 12 (mask 0x13DE). All other bits read as zero.
- R4: Writes to the trap base register (index 8) clear bits 14:0.
- R5: A window pointer write of NWINDOWS or more stores NWINDOWS-1. Smaller values are stored unchanged.
- R6: Each trap-save register (indices 16..20) is an array of MAXTL entries. Reads and writes use entry TL-1, so the value written at one level is read back only at that level.
- R7: A trap-save access while TL is 0 or greater than MAXTL asserts the read or write error flag in that cycle. The read returns 0 and the write changes nothing.
- R8: A write to the trap level sets the interrupt request to (hyp-state bit 0) AND (new stored TL == 0) AND NOT (hyp-state bit 2), using the hypervisor state held before the write.
- R9: The interrupt request holds its value until the next trap-level write, even when the hypervisor state changes.
- R10: Packed word (index 15 and mmu_ctl_o): bit 0 = hyp bit 2, bit 1 = hyp bit 5, bits 3:2 = proc-state bits 3:2, bits 5:4 = LSU bits 3:2, bits 15:8 = partition bits 7:0, bits 18:16 = TL, bits 47:32 = primary context bits 15:0, bits 63:48 = secondary context bits 15:0, other bits 0.
- R11: FPRS reads return the stored value with bits 1:0 forced to one.
- R12: Reads of unimplemented indices (21..23, 40..63) return 0 with rd_err_o high. Writes to those indices or to index 15 raise wr_err_o and change no state.
- R13: The trap level stores only its low clog2(MAXTL+1) bits (3 bits by default), so writing 0xA stores 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 6 | Read register index |
| rd_data_o | output | 64 | Read data, combinational |
| rd_err_o | output | 1 | Illegal read in this cycle |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 6 | Write register index |
| wr_data_i | input | 64 | Write data |
| wr_err_o | output | 1 | Illegal write in this cycle |
| tlz_irq_o | output | 1 | Trap-level-zero interrupt request |
| mmu_ctl_o | output | 64 | Packed MMU control word |

## Verification
The bench sweeps every bit of the processor-state mask and a range of window-pointer values around NWINDOWS, so a wrong mask bit or an off-by-one clamp shows up as a mismatched readback. Trap-save entries are written at every level and read back in reverse order, which exposes a design that ignores TL or indexes entry TL rather than TL-1. Accesses at TL 0 and at TL 7 must not corrupt any stored entry. All four combinations of the two hypervisor bits are tried at TL 0 and TL 1, followed by a hypervisor write with no TL write, so a request computed continuously instead of latched on TL writes would toggle. A read in the cycle of a write catches a bypass that returns the new value early.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int unsigned IDXW = 6;
  localparam int unsigned XLEN = 64;

  localparam logic [IDXW-1:0] IDX_ASI    = 6'd0;
  localparam logic [IDXW-1:0] IDX_FPRS   = 6'd1;
  localparam logic [IDXW-1:0] IDX_PSTATE = 6'd2;
  localparam logic [IDXW-1:0] IDX_TL     = 6'd3;
  localparam logic [IDXW-1:0] IDX_PIL    = 6'd4;
  localparam logic [IDXW-1:0] IDX_CWP    = 6'd5;
  localparam logic [IDXW-1:0] IDX_GL     = 6'd6;
  localparam logic [IDXW-1:0] IDX_HYP    = 6'd7;
  localparam logic [IDXW-1:0] IDX_TBA    = 6'd8;
  localparam logic [IDXW-1:0] IDX_HTBA   = 6'd9;
  localparam logic [IDXW-1:0] IDX_PCTX   = 6'd10;
  localparam logic [IDXW-1:0] IDX_SCTX   = 6'd11;
  localparam logic [IDXW-1:0] IDX_PART   = 6'd12;
  localparam logic [IDXW-1:0] IDX_LSU    = 6'd13;
  localparam logic [IDXW-1:0] IDX_STRAND = 6'd14;
  localparam logic [IDXW-1:0] IDX_MMU    = 6'd15;

  localparam int unsigned TS_BASE  = 16;
  localparam int unsigned TS_N     = 5;
  localparam int unsigned AUX_BASE = 24;
  localparam int unsigned AUX_N    = 16;   // 8 scratch + 8 queue pointers

  localparam logic [XLEN-1:0] PSTATE_MASK = 64'h0000_0000_0000_13DE;
  localparam logic [XLEN-1:0] TBA_MASK    = ~64'h7FFF;
  localparam logic [XLEN-1:0] HYP_RST     = 64'h800;
  localparam logic [XLEN-1:0] STRAND_RST  = 64'h5_0000;

  localparam int unsigned HYP_TLZ_BIT   = 0;
  localparam int unsigned HYP_HPRIV_BIT = 2;
  localparam int unsigned HYP_RED_BIT   = 5;

  function automatic logic idx_is_trap(logic [IDXW-1:0] i);
    return (i >= IDXW'(TS_BASE)) && (i < IDXW'(TS_BASE + TS_N));
  endfunction

  function automatic logic idx_is_scalar(logic [IDXW-1:0] i);
    return (i <= IDX_MMU) ||
           ((i >= IDXW'(AUX_BASE)) && (i < IDXW'(AUX_BASE + AUX_N)));
  endfunction
endpackage

// File: rtl/pcr_scalar_bank.sv
module pcr_scalar_bank
  import pcr_pkg::*;
#(
  parameter int unsigned NWINDOWS = 8,
  parameter int unsigned TLW      = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic [TLW-1:0]  tl_o,
  output logic            hyp_tlz_o,
  output logic            hyp_hpriv_o,
  output logic            hyp_red_o,
  output logic [1:0]      ps_mmu_o,
  output logic [1:0]      lsu_mmu_o,
  output logic [7:0]      part_mmu_o,
  output logic [15:0]     pctx_mmu_o,
  output logic [15:0]     sctx_mmu_o
);
  localparam int unsigned CWPW = (NWINDOWS > 1) ? $clog2(NWINDOWS) : 1;

  logic [XLEN-1:0] asi_q, fprs_q, pstate_q, pil_q, gl_q, hyp_q, tba_q, htba_q;
  logic [XLEN-1:0] pctx_q, sctx_q, part_q, lsu_q, strand_q;
  logic [TLW-1:0]  tl_q;
  logic [CWPW-1:0] cwp_q, cwp_nxt;
  logic [XLEN-1:0] aux_rd [AUX_N];

  // saturate window pointer
  assign cwp_nxt = (wr_data_i >= XLEN'(NWINDOWS)) ? CWPW'(NWINDOWS - 1)
                                                  : wr_data_i[CWPW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asi_q    <= '0;
      fprs_q   <= '0;
      pstate_q <= '0;
      pil_q    <= '0;
      gl_q     <= '0;
      hyp_q    <= HYP_RST;
      tba_q    <= '0;
      htba_q   <= '0;
      pctx_q   <= '0;
      sctx_q   <= '0;
      part_q   <= '0;
      lsu_q    <= '0;
      strand_q <= STRAND_RST;
      tl_q     <= '0;
      cwp_q    <= '0;
    end else if (wr_en_i) begin
      case (wr_idx_i)
        IDX_ASI:    asi_q    <= wr_data_i;
        IDX_FPRS:   fprs_q   <= wr_data_i;
        IDX_PSTATE: pstate_q <= wr_data_i & PSTATE_MASK;
        IDX_TL:     tl_q     <= wr_data_i[TLW-1:0];
        IDX_PIL:    pil_q    <= wr_data_i;
        IDX_CWP:    cwp_q    <= cwp_nxt;
        IDX_GL:     gl_q     <= wr_data_i;
        IDX_HYP:    hyp_q    <= wr_data_i;
        IDX_TBA:    tba_q    <= wr_data_i & TBA_MASK;
        IDX_HTBA:   htba_q   <= wr_data_i;
        IDX_PCTX:   pctx_q   <= wr_data_i;
        IDX_SCTX:   sctx_q   <= wr_data_i;
        IDX_PART:   part_q   <= wr_data_i;
        IDX_LSU:    lsu_q    <= wr_data_i;
        IDX_STRAND: strand_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  // scratch slots and queue pointers
  for (genvar g = 0; g < AUX_N; g++) begin : g_aux
    logic [XLEN-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDXW'(AUX_BASE + g))) val_q <= wr_data_i;
    end
    assign aux_rd[g] = val_q;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_idx_i)
      IDX_ASI:    rd_data_o = asi_q;
      IDX_FPRS:   rd_data_o = fprs_q | XLEN'(3);
      IDX_PSTATE: rd_data_o = pstate_q;
      IDX_TL:     rd_data_o = XLEN'(tl_q);
      IDX_PIL:    rd_data_o = pil_q;
      IDX_CWP:    rd_data_o = XLEN'(cwp_q);
      IDX_GL:     rd_data_o = gl_q;
      IDX_HYP:    rd_data_o = hyp_q;
      IDX_TBA:    rd_data_o = tba_q;
      IDX_HTBA:   rd_data_o = htba_q;
      IDX_PCTX:   rd_data_o = pctx_q;
      IDX_SCTX:   rd_data_o = sctx_q;
      IDX_PART:   rd_data_o = part_q;
      IDX_LSU:    rd_data_o = lsu_q;
      IDX_STRAND: rd_data_o = strand_q;
      default: begin
        for (int g = 0; g < AUX_N; g++)
          if (rd_idx_i == IDXW'(AUX_BASE + g)) rd_data_o = aux_rd[g];
      end
    endcase
  end

  assign tl_o        = tl_q;
  assign hyp_tlz_o   = hyp_q[HYP_TLZ_BIT];
  assign hyp_hpriv_o = hyp_q[HYP_HPRIV_BIT];
  assign hyp_red_o   = hyp_q[HYP_RED_BIT];
  assign ps_mmu_o    = pstate_q[3:2];
  assign lsu_mmu_o   = lsu_q[3:2];
  assign part_mmu_o  = part_q[7:0];
  assign pctx_mmu_o  = pctx_q[15:0];
  assign sctx_mmu_o  = sctx_q[15:0];
endmodule

// File: rtl/pcr_trap_stack.sv
module pcr_trap_stack
  import pcr_pkg::*;
#(
  parameter int unsigned MAXTL = 6,
  parameter int unsigned TLW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [IDXW-1:0] rd_idx_i,
  input  logic [TLW-1:0]  tl_i,
  output logic [XLEN-1:0] rd_data_o
);
  // one bank of save registers per trap level; level L uses entry L-1
  for (genvar l = 0; l < MAXTL; l++) begin : g_lvl
    logic [XLEN-1:0] ent_q [TS_N];
    logic            lvl_sel;
    assign lvl_sel = (tl_i == TLW'(l + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < TS_N; r++) ent_q[r] <= '0;
      end else if (wr_en_i && lvl_sel) begin
        for (int r = 0; r < TS_N; r++)
          if (wr_idx_i == IDXW'(TS_BASE + r)) ent_q[r] <= wr_data_i;
      end
    end
  end

  logic [XLEN-1:0] lvl_rd [MAXTL];
  for (genvar l = 0; l < MAXTL; l++) begin : g_rd
    always_comb begin
      lvl_rd[l] = '0;
      for (int r = 0; r < TS_N; r++)
        if (rd_idx_i == IDXW'(TS_BASE + r)) lvl_rd[l] = g_lvl[l].ent_q[r];
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int l = 0; l < MAXTL; l++)
      if (tl_i == TLW'(l + 1)) rd_data_o = lvl_rd[l];
  end
endmodule

// File: rtl/pcr_mmu_pack.sv
module pcr_mmu_pack
  import pcr_pkg::*;
#(
  parameter int unsigned TLW = 3
) (
  input  logic            hyp_hpriv_i,
  input  logic            hyp_red_i,
  input  logic [1:0]      ps_i,
  input  logic [1:0]      lsu_i,
  input  logic [7:0]      part_i,
  input  logic [TLW-1:0]  tl_i,
  input  logic [15:0]     pctx_i,
  input  logic [15:0]     sctx_i,
  output logic [XLEN-1:0] word_o
);
  logic [2:0] tl3;
  assign tl3 = 3'(tl_i);

  always_comb begin
    word_o        = '0;
    word_o[0]     = hyp_hpriv_i;
    word_o[1]     = hyp_red_i;
    word_o[3:2]   = ps_i;
    word_o[5:4]   = lsu_i;
    word_o[15:8]  = part_i;
    word_o[18:16] = tl3;
    word_o[47:32] = pctx_i;
    word_o[63:48] = sctx_i;
  end
endmodule

// File: rtl/priv_ctrl_regfile.sv
module priv_ctrl_regfile
  import pcr_pkg::*;
#(
  parameter int unsigned MAXTL    = 6,
  parameter int unsigned NWINDOWS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic [5:0]  rd_idx_i,
  output logic [63:0] rd_data_o,
  output logic        rd_err_o,
  input  logic        wr_en_i,
  input  logic [5:0]  wr_idx_i,
  input  logic [63:0] wr_data_i,
  output logic        wr_err_o,
  output logic        tlz_irq_o,
  output logic [63:0] mmu_ctl_o
);
  localparam int unsigned TLW = $clog2(MAXTL + 1);

  logic [TLW-1:0]  tl_w;
  logic            hyp_tlz_w, hyp_hpriv_w, hyp_red_w;
  logic [1:0]      ps_w, lsu_w;
  logic [7:0]      part_w;
  logic [15:0]     pctx_w, sctx_w;
  logic [XLEN-1:0] bank_rd, ts_rd;
  logic            tl_ok, wr_ok, tlz_q;

  assign tl_ok = (tl_w != '0) && (tl_w <= TLW'(MAXTL));

  assign rd_err_o = rd_en_i &&
                    (!(idx_is_scalar(rd_idx_i) || idx_is_trap(rd_idx_i)) ||
                     (idx_is_trap(rd_idx_i) && !tl_ok));
  assign wr_err_o = wr_en_i &&
                    (!(idx_is_scalar(wr_idx_i) || idx_is_trap(wr_idx_i)) ||
                     (wr_idx_i == IDX_MMU) ||
                     (idx_is_trap(wr_idx_i) && !tl_ok));
  assign wr_ok = wr_en_i && !wr_err_o;

  pcr_scalar_bank #(.NWINDOWS(NWINDOWS), .TLW(TLW)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_ok),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .rd_idx_i    (rd_idx_i),
    .rd_data_o   (bank_rd),
    .tl_o        (tl_w),
    .hyp_tlz_o   (hyp_tlz_w),
    .hyp_hpriv_o (hyp_hpriv_w),
    .hyp_red_o   (hyp_red_w),
    .ps_mmu_o    (ps_w),
    .lsu_mmu_o   (lsu_w),
    .part_mmu_o  (part_w),
    .pctx_mmu_o  (pctx_w),
    .sctx_mmu_o  (sctx_w)
  );

  pcr_trap_stack #(.MAXTL(MAXTL), .TLW(TLW)) u_tstk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ok),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_idx_i),
    .tl_i      (tl_w),
    .rd_data_o (ts_rd)
  );

  pcr_mmu_pack #(.TLW(TLW)) u_pack (
    .hyp_hpriv_i (hyp_hpriv_w),
    .hyp_red_i   (hyp_red_w),
    .ps_i        (ps_w),
    .lsu_i       (lsu_w),
    .part_i      (part_w),
    .tl_i        (tl_w),
    .pctx_i      (pctx_w),
    .sctx_i      (sctx_w),
    .word_o      (mmu_ctl_o)
  );

  // request is only re-evaluated on a trap-level write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tlz_q <= 1'b0;
    else if (wr_ok && (wr_idx_i == IDX_TL))
      tlz_q <= hyp_tlz_w && (wr_data_i[TLW-1:0] == '0) && !hyp_hpriv_w;
  end
  assign tlz_irq_o = tlz_q;

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i && !rd_err_o) begin
      if (idx_is_trap(rd_idx_i))     rd_data_o = ts_rd;
      else if (rd_idx_i == IDX_MMU)  rd_data_o = mmu_ctl_o;
      else                           rd_data_o = bank_rd;
    end
  end
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker
  import pcr_pkg::*;
#(
  parameter int unsigned MAXTL    = 6,
  parameter int unsigned NWINDOWS = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_en_i,
  input logic [5:0]  rd_idx_i,
  input logic [63:0] rd_data_o,
  input logic        rd_err_o,
  input logic        wr_en_i,
  input logic [5:0]  wr_idx_i,
  input logic [63:0] wr_data_i,
  input logic        wr_err_o,
  input logic        tlz_irq_o,
  input logic [63:0] mmu_ctl_o,
  input logic        hyp_tlz,
  input logic        hyp_hpriv,
  input logic [$clog2(MAXTL+1)-1:0] tl
);
  localparam int unsigned TLW = $clog2(MAXTL + 1);

  assert_pstate_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i == IDX_PSTATE) |-> ((rd_data_o & ~PSTATE_MASK) == '0));

  assert_tba_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i == IDX_TBA) |-> (rd_data_o[14:0] == '0));

  assert_cwp_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i == IDX_CWP) |-> (rd_data_o < 64'(NWINDOWS)));

  assert_trap_tl_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && idx_is_trap(rd_idx_i) && (tl == '0 || tl > TLW'(MAXTL))) |-> rd_err_o);

  assert_tlz_eval_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_err_o && wr_idx_i == IDX_TL) |=>
      (tlz_irq_o == ($past(hyp_tlz) && ($past(wr_data_i[TLW-1:0]) == '0) && !$past(hyp_hpriv))));

  assert_tlz_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == IDX_TL) |=> $stable(tlz_irq_o));

  assert_mmu_zero_gaps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmu_ctl_o[7:6] == 2'b00) && (mmu_ctl_o[31:19] == '0));

  assert_fprs_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i == IDX_FPRS) |-> (rd_data_o[1:0] == 2'b11));

  assert_err_read_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_data_o == '0));

  assert_err_write_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> ($stable(mmu_ctl_o) && $stable(tlz_irq_o)));
endmodule

bind priv_ctrl_regfile pcr_checker #(.MAXTL(MAXTL), .NWINDOWS(NWINDOWS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en_i),
  .rd_idx_i  (rd_idx_i),
  .rd_data_o (rd_data_o),
  .rd_err_o  (rd_err_o),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .wr_data_i (wr_data_i),
  .wr_err_o  (wr_err_o),
  .tlz_irq_o (tlz_irq_o),
  .mmu_ctl_o (mmu_ctl_o),
  .hyp_tlz   (hyp_tlz_w),
  .hyp_hpriv (hyp_hpriv_w),
  .tl        (tl_w)
);

// File: tb/tb_priv_ctrl_regfile.sv
module tb_priv_ctrl_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        rd_err;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        wr_err;
  logic        tlz_irq;
  logic [63:0] mmu_ctl;

  int nchk = 0;
  int nfail = 0;
  logic last_wr_err;
  logic last_rd_err;
  logic done = 1'b0;

  always #4 clk = ~clk;

  priv_ctrl_regfile #(.MAXTL(6), .NWINDOWS(8)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_err_o(rd_err),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_err_o(wr_err),
    .tlz_irq_o(tlz_irq), .mmu_ctl_o(mmu_ctl)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // write lands at the next rising edge; returns at the following falling edge
  task automatic wr(input logic [5:0] i, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    #1 last_wr_err = wr_err;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] i, output logic [63:0] d);
    rd_en = 1'b1; rd_idx = i;
    #1 d = rd_data; last_rd_err = rd_err;
    rd_en = 1'b0;
  endtask

  function automatic logic [63:0] ts_pat(input int lvl, input int r);
    return 64'hC0DE_0000_0000_0000 | (64'(lvl) << 8) | 64'(r);
  endfunction

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] v, e;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 40; i++) begin
      if (i >= 15 && i <= 23) continue;
      rd(6'(i), v);
      e = (i == 1) ? 64'h3 : (i == 7) ? 64'h800 : (i == 14) ? 64'h5_0000 : 64'h0;
      chk($sformatf("R1 reset idx %0d", i), v, e);
    end
    chk("R1 reset irq", 64'(tlz_irq), 64'h0);
    chk("R1 reset mmu word", mmu_ctl, 64'h0);

    // R2 plain registers keep all bits
    for (int i = 0; i < 40; i++) begin
      if (!(i == 0 || i == 4 || i == 6 || i == 9 || (i >= 10 && i <= 14) || i >= 24)) continue;
      wr(6'(i), 64'hA5A5_0F0F_3C3C_9696 ^ (64'(i) * 64'h0101_0101_0101_0101));
    end
    for (int i = 0; i < 40; i++) begin
      if (!(i == 0 || i == 4 || i == 6 || i == 9 || (i >= 10 && i <= 14) || i >= 24)) continue;
      rd(6'(i), v);
      chk($sformatf("R2 readback idx %0d", i), v,
          64'hA5A5_0F0F_3C3C_9696 ^ (64'(i) * 64'h0101_0101_0101_0101));
    end

    // R2 read during write returns old value
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd30; wr_data = 64'h1111_2222_3333_4444;
    rd_en = 1'b1; rd_idx = 6'd30;
    #1 chk("R2 same-cycle old value", rd_data,
           64'hA5A5_0F0F_3C3C_9696 ^ (64'd30 * 64'h0101_0101_0101_0101));
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R2 new value next cycle", rd_data, 64'h1111_2222_3333_4444);
    rd_en = 1'b0;

    // R3 processor state mask, one bit at a time
    for (int b = 0; b < 64; b++) begin
      wr(6'd2, 64'h1 << b);
      rd(6'd2, v);
      chk($sformatf("R3 pstate bit %0d", b), v, (64'h1 << b) & 64'h13DE);
    end

    // R4 trap base
    wr(6'd8, 64'hFFFF_FFFF_FFFF_FFFF); rd(6'd8, v);
    chk("R4 tba all ones", v, 64'hFFFF_FFFF_FFFF_8000);
    wr(6'd8, 64'h0000_1234_5678_ABCD); rd(6'd8, v);
    chk("R4 tba pattern", v, 64'h0000_1234_5678_8000);

    // R5 window pointer saturation
    for (int k = 0; k < 20; k++) begin
      wr(6'd5, 64'(k)); rd(6'd5, v);
      chk($sformatf("R5 cwp %0d", k), v, (k >= 8) ? 64'd7 : 64'(k));
    end
    wr(6'd5, 64'h8000_0000_0000_0003); rd(6'd5, v);
    chk("R5 cwp huge", v, 64'd7);

    // R6 trap stack per level
    for (int l = 1; l <= 6; l++) begin
      wr(6'd3, 64'(l));
      for (int r = 0; r < 5; r++) wr(6'(16 + r), ts_pat(l, r));
    end
    for (int l = 6; l >= 1; l--) begin
      wr(6'd3, 64'(l));
      for (int r = 0; r < 5; r++) begin
        rd(6'(16 + r), v);
        chk($sformatf("R6 tl %0d reg %0d", l, r), v, ts_pat(l, r));
      end
    end

    // R7 trap access at TL 0 and TL 7
    wr(6'd3, 64'd0);
    rd(6'd16, v);
    chk("R7 tl0 read err", 64'(last_rd_err), 64'h1);
    chk("R7 tl0 read data", v, 64'h0);
    wr(6'd16, 64'hDEAD);
    chk("R7 tl0 write err", 64'(last_wr_err), 64'h1);
    wr(6'd3, 64'd7);
    rd(6'd17, v);
    chk("R7 tl7 read err", 64'(last_rd_err), 64'h1);
    wr(6'd17, 64'hBEEF);
    chk("R7 tl7 write err", 64'(last_wr_err), 64'h1);
    wr(6'd3, 64'd1); rd(6'd16, v);
    chk("R7 tl1 entry untouched", v, ts_pat(1, 0));
    for (int l = 1; l <= 6; l++) begin
      wr(6'd3, 64'(l)); rd(6'd17, v);
      chk($sformatf("R7 tl %0d reg1 untouched", l), v, ts_pat(l, 1));
    end

    // R8 interrupt request combinations
    for (int h = 0; h < 4; h++) begin
      for (int t = 0; t < 2; t++) begin
        wr(6'd7, (h[0] ? 64'h1 : 64'h0) | (h[1] ? 64'h4 : 64'h0));
        wr(6'd3, 64'(t));
        chk($sformatf("R8 irq tlz=%0d hpriv=%0d tl=%0d", h[0], h[1], t), 64'(tlz_irq),
            64'(h[0] && !h[1] && t == 0));
      end
    end

    // R9 request held across hypervisor-state changes
    wr(6'd7, 64'h1); wr(6'd3, 64'd0);
    chk("R9 irq set", 64'(tlz_irq), 64'h1);
    wr(6'd7, 64'h4);
    chk("R9 irq held after hyp write", 64'(tlz_irq), 64'h1);
    wr(6'd3, 64'd1);
    chk("R9 irq cleared by tl write", 64'(tlz_irq), 64'h0);

    // R13 trap level width, and R8 on truncated value
    wr(6'd7, 64'h1);
    wr(6'd3, 64'hA); rd(6'd3, v);
    chk("R13 tl truncated", v, 64'd2);
    wr(6'd3, 64'h8); rd(6'd3, v);
    chk("R13 tl 8 stores 0", v, 64'd0);
    chk("R8 irq on truncated zero", 64'(tlz_irq), 64'h1);

    // R10 packed word
    wr(6'd7, 64'h24); wr(6'd2, 64'hC); wr(6'd13, 64'hC); wr(6'd12, 64'h1A5);
    wr(6'd3, 64'd5); wr(6'd10, 64'hFFFF_1234); wr(6'd11, 64'h5678);
    e = 64'h3 | 64'hC | 64'h30 | (64'hA5 << 8) | (64'd5 << 16) |
        (64'h1234 << 32) | (64'h5678 << 48);
    chk("R10 mmu port", mmu_ctl, e);
    rd(6'd15, v);
    chk("R10 mmu index read", v, e);
    wr(6'd7, 64'hFFDB); wr(6'd2, 64'h3); wr(6'd13, 64'h3); wr(6'd3, 64'd2);
    e = (64'hA5 << 8) | (64'd2 << 16) | (64'h1234 << 32) | (64'h5678 << 48);
    chk("R10 mmu second pattern", mmu_ctl, e);

    // R11 FPRS read forcing
    wr(6'd1, 64'h0); rd(6'd1, v);
    chk("R11 fprs zero", v, 64'h3);
    wr(6'd1, 64'h4); rd(6'd1, v);
    chk("R11 fprs 4", v, 64'h7);

    // R12 unimplemented and read-only indices
    for (int i = 21; i < 64; i++) begin
      if (i >= 24 && i < 40) continue;
      rd(6'(i), v);
      chk($sformatf("R12 rd err idx %0d", i), 64'(last_rd_err), 64'h1);
      chk($sformatf("R12 rd data idx %0d", i), v, 64'h0);
    end
    wr(6'd15, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R12 write packed word err", 64'(last_wr_err), 64'h1);
    chk("R12 packed word unchanged", mmu_ctl, e);
    wr(6'd45, 64'h1);
    chk("R12 write unimpl err", 64'(last_wr_err), 64'h1);
    rd(6'd24, v);
    chk("R12 neighbour unchanged", v,
        64'hA5A5_0F0F_3C3C_9696 ^ (64'd24 * 64'h0101_0101_0101_0101));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule